// File: doc/BRIEF.md
# One-Bit Tape Pointer Machine

This block is a minimal processor for a five-instruction tape language. Its data memory is a tape of single-bit cells addressed by a data pointer. It fetches one 3-bit instruction code per cycle from an external program ROM through a combinational read port (address out, code in). A program counter walks the ROM. Instructions invert the bit under the pointer, step the pointer one cell either way, or form loops with a pair of bracket instructions that may be nested.

When a bracket must jump, the core finds the partner bracket itself. It steps the program counter one address per cycle in the scan direction and keeps a nesting-depth count. No bracket table is precomputed. The machine stops and raises a halt flag on an explicit halt code, when it runs past the last program address, or when a bracket scan finds no partner. A debug port reads any tape cell at any time, so software or a bench can inspect the result.

Reset is asynchronous and active low, and its release is synchronised inside the block. Reset clears the tape and returns both the program counter and the data pointer to 0.

Top module: `bit_tape_cpu`

## Requirements
- R1: While reset is asserted, every tape cell reads 0 on the debug port, `prog_addr` is 0 and `halted` is low. A reset after a run clears what that run wrote.
- R2: Code 3'b001 inverts the tape cell under the data pointer and moves on to the next address.
- R3: Code 3'b010 moves the data pointer one cell up and code 3'b011 moves it one cell down. The pointer wraps modulo 2^TAPE_AW in both directions.
- R4: Code 3'b100 (open) with a 0 under the pointer continues at the address after its matching close (3'b101), honouring nesting. Instructions passed over during the scan do not change the tape or the pointer.
- R5: Code 3'b101 (close) with a 1 under the pointer continues at the address after its matching open, honouring nesting.
- R6: An open with a 1 under the pointer, or a close with a 0 under it, simply moves on to the next address.
- R7: Code 3'b000 halts. After a halt, `halted` stays high, `prog_addr` stays fixed and the tape no longer changes.
- R8: Execution moving past the last program address (2^PC_W-1) halts. Codes 3'b110 and 3'b111 have no effect other than advancing.
- R9: A forward scan that reaches the last address without finding its match halts the machine, and so does a backward scan that reaches address 0 without finding its match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_addr | output | PC_W | Program ROM read address (the program counter) |
| prog_code | input | 3 | Instruction code read combinationally from `prog_addr` |
| halted | output | 1 | High once execution has stopped |
| dbg_addr | input | TAPE_AW | Tape cell to read on the debug port |
| dbg_bit | output | 1 | Value of tape cell `dbg_addr` |

## Verification
The bench builds the block with PC_W=5 and TAPE_AW=4, so the program holds 32 codes and the tape holds 16 cells. With these values a few moves are enough to wrap the pointer past either end of the tape. Runs that fall off the end of the program, and forward scans that find no partner, finish within tens of cycles. The bench covers forward skips over nested pairs, backward jumps across an inner pair, and a close at the start of a program with no partner. Each program's final tape is compared against a reference interpreter.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam logic [2:0] OP_HALT  = 3'b000;
  localparam logic [2:0] OP_FLIP  = 3'b001;
  localparam logic [2:0] OP_RIGHT = 3'b010;
  localparam logic [2:0] OP_LEFT  = 3'b011;
  localparam logic [2:0] OP_OPEN  = 3'b100;
  localparam logic [2:0] OP_CLOSE = 3'b101;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_FWD  = 2'd1,
    ST_BWD  = 2'd2,
    ST_STOP = 2'd3
  } bt_state_e;
endpackage

// File: rtl/bt_tape.sv
module bt_tape #(
  parameter int TAPE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flip_en,
  input  logic [TAPE_AW-1:0] flip_addr,
  output logic               cur_bit,
  input  logic [TAPE_AW-1:0] dbg_addr,
  output logic               dbg_bit
);
  localparam int CELLS = 1 << TAPE_AW;

  logic [CELLS-1:0] tape_q, tape_d;

  always_comb begin
    tape_d = tape_q;
    if (flip_en) tape_d[flip_addr] = ~tape_q[flip_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tape_q <= '0;
    else        tape_q <= tape_d;
  end

  assign cur_bit = tape_q[flip_addr];
  assign dbg_bit = tape_q[dbg_addr];

  a_r2_flip_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    flip_en |=> tape_q[$past(flip_addr)] != $past(tape_q[flip_addr]));

  a_r4_idle_tape_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_en |=> $stable(tape_q));
endmodule

// File: rtl/bt_dptr.sv
module bt_dptr #(
  parameter int TAPE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_up,
  input  logic               step_down,
  output logic [TAPE_AW-1:0] dp
);
  logic [TAPE_AW-1:0] dp_q, dp_d;

  always_comb begin
    dp_d = dp_q;
    if (step_up)        dp_d = dp_q + 1'b1;
    else if (step_down) dp_d = dp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dp_q <= '0;
    else        dp_q <= dp_d;
  end

  assign dp = dp_q;

  a_r3_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_down));
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int DEPTH_W = PC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      code,
  input  logic            cur_bit,
  output logic [PC_W-1:0] pc,
  output logic            halted,
  output logic            scanning,
  output logic            flip_en,
  output logic            step_up,
  output logic            step_down
);
  localparam logic [PC_W-1:0] PC_LAST = '1;

  bt_state_e           state_q, state_d;
  logic [PC_W-1:0]     pc_q, pc_d;
  logic [DEPTH_W-1:0]  depth_q, depth_d;
  logic                adv;
  logic                at_last, at_first;

  assign at_last  = (pc_q == PC_LAST);
  assign at_first = (pc_q == '0);

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    depth_d   = depth_q;
    flip_en   = 1'b0;
    step_up   = 1'b0;
    step_down = 1'b0;
    adv       = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        adv = 1'b1;
        case (code)
          OP_HALT: begin
            adv     = 1'b0;
            state_d = ST_STOP;
          end
          OP_FLIP:  flip_en   = 1'b1;
          OP_RIGHT: step_up   = 1'b1;
          OP_LEFT:  step_down = 1'b1;
          OP_OPEN: begin
            if (!cur_bit) begin
              depth_d = '0;
              state_d = ST_FWD;
            end
          end
          OP_CLOSE: begin
            if (cur_bit) begin
              adv     = 1'b0;
              depth_d = '0;
              if (at_first) state_d = ST_STOP;
              else begin
                pc_d    = pc_q - 1'b1;
                state_d = ST_BWD;
              end
            end
          end
          default: ;
        endcase
      end
      ST_FWD: begin
        adv = 1'b1;
        if (code == OP_OPEN) depth_d = depth_q + 1'b1;
        else if (code == OP_CLOSE) begin
          if (depth_q == '0) state_d = ST_RUN;
          else               depth_d = depth_q - 1'b1;
        end
      end
      ST_BWD: begin
        if (code == OP_OPEN && depth_q == '0) begin
          state_d = ST_RUN;
          adv     = 1'b1;
        end else begin
          if (code == OP_OPEN)       depth_d = depth_q - 1'b1;
          else if (code == OP_CLOSE) depth_d = depth_q + 1'b1;
          if (at_first) state_d = ST_STOP;
          else          pc_d    = pc_q - 1'b1;
        end
      end
      default: ;
    endcase
    if (adv) begin
      if (at_last) state_d = ST_STOP;
      else         pc_d    = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pc_q    <= '0;
      depth_q <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      depth_q <= depth_d;
    end
  end

  assign pc       = pc_q;
  assign halted   = (state_q == ST_STOP);
  assign scanning = (state_q == ST_FWD) || (state_q == ST_BWD);

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_q));

  a_r4_fwd_scan_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FWD && !at_last) |=> pc_q == $past(pc_q) + 1'b1);

  a_r5_bwd_scan_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BWD && code != OP_OPEN && !at_first) |=> pc_q == $past(pc_q) - 1'b1);

  a_r4_scan_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> !flip_en && !step_up && !step_down);
endmodule

// File: rtl/bit_tape_cpu.sv
module bit_tape_cpu #(
  parameter int PC_W    = 8,
  parameter int TAPE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    prog_addr,
  input  logic [2:0]         prog_code,
  output logic               halted,
  input  logic [TAPE_AW-1:0] dbg_addr,
  output logic               dbg_bit
);
  localparam int DEPTH_W = PC_W;

  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic               flip_en, step_up, step_down, cur_bit, scanning;
  logic [TAPE_AW-1:0] dp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  bt_ctrl #(.PC_W(PC_W), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .code      (prog_code),
    .cur_bit   (cur_bit),
    .pc        (prog_addr),
    .halted    (halted),
    .scanning  (scanning),
    .flip_en   (flip_en),
    .step_up   (step_up),
    .step_down (step_down)
  );

  bt_dptr #(.TAPE_AW(TAPE_AW)) u_dptr (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .step_up   (step_up),
    .step_down (step_down),
    .dp        (dp)
  );

  bt_tape #(.TAPE_AW(TAPE_AW)) u_tape (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .flip_en   (flip_en),
    .flip_addr (dp),
    .cur_bit   (cur_bit),
    .dbg_addr  (dbg_addr),
    .dbg_bit   (dbg_bit)
  );

  a_r4_scan_holds_pointer: assert property (@(posedge clk) disable iff (!core_rst_n)
    scanning |=> $stable(dp));

  a_r3_pointer_single_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dp != $past(dp)) |-> ((dp == $past(dp) + 1'b1) || (dp == $past(dp) - 1'b1)));
endmodule

// File: tb/test_bit_tape_cpu.sv
module test_bit_tape_cpu;
  localparam int PCW = 5;
  localparam int TAW = 4;
  localparam int PN  = 1 << PCW;
  localparam int TN  = 1 << TAW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [PCW-1:0] prog_addr;
  logic [2:0]     prog_code;
  logic           halted;
  logic [TAW-1:0] dbg_addr = '0;
  logic           dbg_bit;

  logic [2:0]     rom [PN];
  int             n_checks = 0;
  int             n_errors = 0;

  string          exp_tag_q[$];
  logic [TN-1:0]  exp_tape_q[$];
  event           run_done, mon_ack;

  always #10 clk = ~clk;

  assign prog_code = rom[prog_addr];

  bit_tape_cpu #(.PC_W(PCW), .TAPE_AW(TAW)) i_bit_tape_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_addr (prog_addr),
    .prog_code (prog_code),
    .halted    (halted),
    .dbg_addr  (dbg_addr),
    .dbg_bit   (dbg_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] enc(input byte c);
    case (c)
      "x": return 3'b001;
      ">": return 3'b010;
      "<": return 3'b011;
      "[": return 3'b100;
      "]": return 3'b101;
      "h": return 3'b000;
      "n": return 3'b110;
      "m": return 3'b111;
      default: return 3'b110;
    endcase
  endfunction

  function automatic logic [TN-1:0] ref_run();
    int pc = 0, dp = 0, d, j;
    bit stop = 0, found;
    logic [TN-1:0] t = '0;
    for (int s = 0; s < 5000 && !stop; s++) begin
      if (pc >= PN) stop = 1;
      else begin
        case (rom[pc])
          3'b000: stop = 1;
          3'b001: begin t[dp] = ~t[dp]; pc++; end
          3'b010: begin dp = (dp + 1) % TN; pc++; end
          3'b011: begin dp = (dp + TN - 1) % TN; pc++; end
          3'b100: begin
            if (t[dp]) pc++;
            else begin
              d = 0; found = 0; j = pc + 1;
              while (j < PN && !found) begin
                if (rom[j] == 3'b100) d++;
                else if (rom[j] == 3'b101) begin
                  if (d == 0) found = 1; else d--;
                end
                if (!found) j++;
              end
              pc = found ? j + 1 : PN;
            end
          end
          3'b101: begin
            if (!t[dp]) pc++;
            else begin
              d = 0; found = 0; j = pc - 1;
              while (j >= 0 && !found) begin
                if (rom[j] == 3'b101) d++;
                else if (rom[j] == 3'b100) begin
                  if (d == 0) found = 1; else d--;
                end
                if (!found) j--;
              end
              pc = found ? j + 1 : PN;
            end
          end
          default: pc++;
        endcase
      end
    end
    return t;
  endfunction

  task automatic check_reset_state(input string req);
    check(halted == 1'b0, {req, " halted low in reset"}, halted, 0);
    check(prog_addr == '0, {req, " prog_addr zero in reset"}, prog_addr, 0);
    for (int a = 0; a < TN; a++) begin
      dbg_addr = a[TAW-1:0];
      #1;
      check(dbg_bit == 1'b0, {req, " tape clear in reset"}, dbg_bit, 0);
    end
  endtask

  // Driver: loads the program, pushes the expected tape, runs to halt.
  task automatic run_prog(input string tag, input string prog, input byte fill);
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < PN; a++) rom[a] = enc(a < prog.len() ? prog[a] : fill);
    #1;
    check_reset_state("R1");
    exp_tag_q.push_back(tag);
    exp_tape_q.push_back(ref_run());
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    check(halted == 1'b1, {tag, " reaches halt"}, halted, 1);
    ->run_done;
    @(mon_ack);
  endtask

  // Monitor: pops the expected tape and compares after halt.
  initial begin
    forever begin
      string         tag;
      logic [TN-1:0] exp_t;
      logic [PCW-1:0] addr0;
      @(run_done);
      tag   = exp_tag_q.pop_front();
      exp_t = exp_tape_q.pop_front();
      addr0 = prog_addr;
      repeat (4) @(negedge clk);
      check(halted == 1'b1, {"R7 ", tag, " halt stays high"}, halted, 1);
      check(prog_addr == addr0, {"R7 ", tag, " prog_addr frozen"}, prog_addr, addr0);
      for (int a = 0; a < TN; a++) begin
        dbg_addr = a[TAW-1:0];
        #1;
        check(dbg_bit == exp_t[a], {tag, " tape cell"}, dbg_bit, exp_t[a]);
      end
      ->mon_ack;
    end
  end

  initial begin
    #(20 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < PN; a++) rom[a] = 3'b000;
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    run_prog("R2 R3 basic flips and moves", "x>>x<xh", "h");
    run_prog("R3 pointer wrap both ways", "<x>>xh", "h");
    run_prog("R4 skip simple loop", "[>x]xh", "h");
    run_prog("R4 skip nested loops", "[[x]>]>xh", "h");
    run_prog("R5 backward loop twice", "x>x<[x>]xh", "h");
    run_prog("R5 backward over inner pair", "x>x<[x[]>]xh", "h");
    run_prog("R6 fall through brackets", "x[>]x<xh", "h");
    run_prog("R7 halt code stops early", "xhx>x", "h");
    run_prog("R8 run past last address", "xmn>x", "n");
    run_prog("R9 unmatched open", "[x", "n");
    run_prog("R9 unmatched close", "x]xh", "h");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1 after run");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule